// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block sits between two 8-bit buses, A and B, and moves data between them under the control of a direction input and an active-low output enable. Each bus has its own storage register. A rising edge on that bus's capture strobe loads the register with the data on the bus. On the driven side an output multiplexer picks either the live data arriving from the other bus or the stored copy of it. Each bus has separate input, output and output-enable ports, so the block contains no internal tri-states. The pad ring or the bus fabric merges them into a physical bus.

The two capture strobes are sampled on the system clock `clk`. A capture happens on the first clock edge at which a strobe is seen high after being low. Capture does not depend on the enable or the direction, so a bus can be recorded while both sides are isolated and sent on later. The live path is combinational from the opposite bus input to the driven output. A parameter selects a non-inverting or an inverting data path. The inverting path drives the bitwise complement of whichever source is selected.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, both registers are cleared to zero and the strobe edge detectors are cleared. A stored read after reset returns 0x00, or 0xFF on the inverting variant.
- R2: The first `clk` edge at which `cap_ab` is high after being low stores `a_in` in the A register. While `cap_ab` stays high, later edges store nothing, and while it is low the register holds its value.
- R3: The first `clk` edge at which `cap_ba` is high after being low stores `b_in` in the B register. The same hold rules as R2 apply.
- R4: Captures take place whatever the values of `oe_n` and `dir`, including while both buses are isolated.
- R5: When `oe_n` is 1, `a_oe` and `b_oe` are both 0.
- R6: When `oe_n` is 0 and `dir` is 0, `a_oe` is 1 and `b_oe` is 0. With `sel_ba` = 0, `a_out` follows `b_in` combinationally in the same cycle.
- R7: When `oe_n` is 0, `dir` is 0 and `sel_ba` is 1, `a_out` shows the B register.
- R8: When `oe_n` is 0 and `dir` is 1, `b_oe` is 1 and `a_oe` is 0. `b_out` follows `a_in` live when `sel_ab` = 0 and shows the A register when `sel_ab` = 1.
- R9: Whenever a bus's output enable is 0, that bus's output port reads 0x00.
- R10: With `INVERT` = 1, the driven output is the bitwise complement of the selected live or stored data.
- R11: If both strobes rise at the same clock edge, both registers capture their buses at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples the capture strobes |
| rst | input | 1 | Synchronous active-high reset of both registers |
| a_in | input | WIDTH | Data seen on bus A |
| b_in | input | WIDTH | Data seen on bus B |
| cap_ab | input | 1 | Capture strobe for the A register (rising edge) |
| cap_ba | input | 1 | Capture strobe for the B register (rising edge) |
| oe_n | input | 1 | Active-low output enable for both buses |
| dir | input | 1 | 0: drive bus A, 1: drive bus B |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B |
| a_out | output | WIDTH | Data driven toward bus A, zero when not enabled |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | WIDTH | Data driven toward bus B, zero when not enabled |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the two captures. The second is a capture on one side while that side's stored value is being driven out of the other side. The bench raises both strobes between the same pair of clock edges with different patterns on each bus, then reads each register back through its stored-data path to confirm that both took their own bus. It also stores while the buses are isolated and then enables the transfer, checking that the stored value appears only after the capture edge. Every value is compared against a model kept in the bench for both the plain and the inverting variants.

// File: rtl/txr_pkg.sv
package txr_pkg;
  // Output source choice made by the select inputs
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/txr_capture_reg.sv
module txr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic stb_q;
  logic load;

  assign load = stb & ~stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= 1'b0;
      q     <= '0;
    end else begin
      stb_q <= stb;
      if (load) q <= d;
    end
  end

  // R1: reset clears the register
  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> q == '0);
  // R2/R3: a new strobe edge loads the bus value
  assert_edge_loads_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(stb) |=> q == $past(d));
  // R2/R3: no strobe, no change
  assert_hold_low_R3: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(q));
endmodule

// File: rtl/txr_out_mux.sv
module txr_out_mux
  import txr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             en,
  input  src_sel_e         sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] dout,
  output logic             oe
);
  logic [WIDTH-1:0] raw;
  logic [WIDTH-1:0] shaped;

  always_comb begin
    raw = (sel == SRC_STORED) ? stored : live;
  end

  generate
    if (INVERT) begin : g_inv
      assign shaped = ~raw;
    end else begin : g_pass
      assign shaped = raw;
    end
  endgenerate

  assign oe   = en;
  assign dout = en ? shaped : '0;
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import txr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             cap_ab,
  input  logic             cap_ba,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  logic [WIDTH-1:0] reg_a;
  logic [WIDTH-1:0] reg_b;
  logic             drive_a;
  logic             drive_b;

  assign drive_a = ~oe_n & ~dir;
  assign drive_b = ~oe_n &  dir;

  txr_capture_reg #(.WIDTH(WIDTH)) u_reg_a (
    .clk(clk), .rst(rst), .stb(cap_ab), .d(a_in), .q(reg_a)
  );

  txr_capture_reg #(.WIDTH(WIDTH)) u_reg_b (
    .clk(clk), .rst(rst), .stb(cap_ba), .d(b_in), .q(reg_b)
  );

  txr_out_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_mux_a (
    .en(drive_a), .sel(src_sel_e'(sel_ba)), .live(b_in), .stored(reg_b),
    .dout(a_out), .oe(a_oe)
  );

  txr_out_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_mux_b (
    .en(drive_b), .sel(src_sel_e'(sel_ab)), .live(a_in), .stored(reg_a),
    .dout(b_out), .oe(b_oe)
  );

  always_comb begin
    // R5: isolation drives neither bus
    assert_isolated_R5: assert (!(oe_n && (a_oe || b_oe)));
    // R6/R8: never both sides at once
    assert_one_side_R6: assert ($onehot0({a_oe, b_oe}));
    // R9: undriven buses read zero
    assert_quiet_R9: assert ((a_oe || a_out == '0) && (b_oe || b_out == '0));
  end

  // R4: capture proceeds during isolation
  assert_store_isolated_R4: assert property (@(posedge clk) disable iff (rst)
    (oe_n && $rose(cap_ab)) |=> reg_a == $past(a_in));
  // R11: simultaneous edges load both registers
  assert_dual_capture_R11: assert property (@(posedge clk) disable iff (rst)
    ($rose(cap_ab) && $rose(cap_ba)) |=> (reg_a == $past(a_in) && reg_b == $past(b_in)));
endmodule

// File: tb/tb_bus_xcvr_reg.sv
module tb_bus_xcvr_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         cap_ab = 1'b0, cap_ba = 1'b0;
  logic         oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_out, b_out, ia_out, ib_out;
  logic         a_oe, b_oe, ia_oe, ib_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [W-1:0] m_a = '0, m_b = '0;  // bench model of stored values

  always #5 clk = ~clk;

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b0)) dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b1)) dut_inv (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_out(ia_out), .a_oe(ia_oe), .b_out(ib_out), .b_oe(ib_oe)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_oe(input string tag, input logic ao, input logic bo,
                        input logic ea, input logic eb);
    checks++;
    if ({ao, bo} !== {ea, eb}) begin
      errors++;
      $display("FAIL %s: actual oe=%b%b expected oe=%b%b", tag, ao, bo, ea, eb);
    end
  endtask

  // Drive controls mid-cycle, then settle before sampling
  task automatic ctl(input logic oen, input logic d, input logic sab, input logic sba);
    oe_n = oen; dir = d; sel_ab = sab; sel_ba = sba;
    #1;
  endtask

  task automatic pulse(input logic pa, input logic pb);
    @(negedge clk);
    cap_ab = pa; cap_ba = pb;
    if (pa) m_a = a_in;
    if (pb) m_b = b_in;
    @(negedge clk);
    cap_ab = 1'b0; cap_ba = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    ctl(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R1 stored B after reset", a_out, 8'h00);
    chk("R1 R10 inverted stored B after reset", ia_out, 8'hFF);
    ctl(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R1 stored A after reset", b_out, 8'h00);
    a_in = 8'h5A; pulse(1'b1, 1'b0);
    chk("R2 stored A before re-reset", b_out, 8'h5A);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; m_a = '0; m_b = '0; #1;
    chk("R1 reset clears stored A", b_out, 8'h00);
  endtask

  task automatic t_isolate();
    ctl(1'b1, 1'b0, 1'b1, 1'b1);
    chk_oe("R5 isolated dir0", a_oe, b_oe, 1'b0, 1'b0);
    chk("R9 a_out zero isolated", a_out, 8'h00);
    chk("R9 inverted a_out zero isolated", ia_out, 8'h00);
    ctl(1'b1, 1'b1, 1'b1, 1'b1);
    chk_oe("R5 isolated dir1", a_oe, b_oe, 1'b0, 1'b0);
    chk("R9 b_out zero isolated", b_out, 8'h00);
    a_in = 8'h3C; pulse(1'b1, 1'b0);
    ctl(1'b1, 1'b0, 1'b1, 1'b1);
    b_in = 8'hC3; pulse(1'b0, 1'b1);
    a_in = 8'h00; b_in = 8'h00;
    ctl(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R4 R8 stored A after isolated capture", b_out, m_a);
    chk("R10 inverted stored A", ib_out, ~m_a);
    ctl(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R4 R7 stored B after isolated capture", a_out, m_b);
    chk("R10 inverted stored B", ia_out, ~m_b);
  endtask

  task automatic t_live_ba();
    b_in = 8'h96;
    ctl(1'b0, 1'b0, 1'b0, 1'b0);
    chk_oe("R6 dir0 enables A only", a_oe, b_oe, 1'b1, 1'b0);
    chk("R6 live B to A", a_out, 8'h96);
    chk("R9 b_out zero while A driven", b_out, 8'h00);
    b_in = 8'h11; #1;
    chk("R6 live B follows same cycle", a_out, 8'h11);
    chk("R10 inverted live B", ia_out, 8'hEE);
  endtask

  task automatic t_live_ab();
    a_in = 8'h77;
    ctl(1'b0, 1'b1, 1'b0, 1'b0);
    chk_oe("R8 dir1 enables B only", a_oe, b_oe, 1'b0, 1'b1);
    chk("R8 live A to B", b_out, 8'h77);
    chk("R9 a_out zero while B driven", a_out, 8'h00);
    chk("R10 inverted live A", ib_out, 8'h88);
  endtask

  task automatic t_held_strobe();
    ctl(1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk); a_in = 8'hA1; cap_ab = 1'b1; m_a = 8'hA1;
    @(negedge clk); a_in = 8'hB2;
    @(negedge clk); @(negedge clk); cap_ab = 1'b0; #1;
    chk("R2 held strobe stores once", b_out, 8'hA1);
    @(negedge clk); a_in = 8'hC4; @(negedge clk); #1;
    chk("R2 strobe low holds", b_out, 8'hA1);
    ctl(1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk); b_in = 8'h42; cap_ba = 1'b1; m_b = 8'h42;
    @(negedge clk); b_in = 8'h24;
    @(negedge clk); cap_ba = 1'b0; #1;
    chk("R3 held strobe stores once", a_out, 8'h42);
  endtask

  task automatic t_dual();
    a_in = 8'h5E; b_in = 8'hE5;
    ctl(1'b0, 1'b0, 1'b1, 1'b1);
    pulse(1'b1, 1'b1);
    a_in = 8'h00; b_in = 8'h00; #1;
    chk("R11 dual capture B", a_out, 8'hE5);
    ctl(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R11 dual capture A", b_out, 8'h5E);
    chk("R10 inverted dual A", ib_out, 8'hA1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0; #1;
    t_reset();
    t_isolate();
    t_live_ba();
    t_live_ab();
    t_held_strobe();
    t_dual();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule